// File: doc/BRIEF.md
# Serial Link Bring-Up Recovery Sequencer

This block supervises the start-up of a multi-lane serial port. A start pulse launches it. It first confirms that the transceiver has left reset, then watches the port status for a link that came up at the configured width. A link set up for one lane is accepted on the port-good status alone. A link set up for four lanes must also report the full four-lane width code. This catches a link that came up but quietly fell back to a narrower width.

When the first check fails, the sequencer runs up to three recovery attempts. Each attempt holds the port disabled with outbound traffic discarded, pulses receive reset on the lanes in use, strobes a clear of the link status, re-enables the port, lets it settle and checks again. After a successful check it waits for the output-error condition to clear, then pulses the error-status clear strobes and ends in done. Every wait is a cycle count derived from the clock frequency parameter. A shared down-counter times all of them.

Top module: `lnk_recover_seq`

## Requirements
- R1: A start with `xcvr_rst_done` low puts the block in fail one cycle after the start edge, with no recovery activity.
- R2: After a valid start the block polls `port_ok` for POLL cycles. In single-lane mode (`wide_mode`=0) `port_ok` alone is success, and `init_width` is ignored.
- R3: In four-lane mode success needs `port_ok` with `init_width` equal to 3'b010. `port_ok` with any other code starts recovery at once, and a poll window that expires without `port_ok` also starts recovery.
- R4: Each attempt asserts `port_disable` and `tx_discard` together for QUIESCE cycles before any lane reset. Later `tx_discard` drops one cycle before `port_disable`.
- R5: `lane_rx_rst_n` is driven low (reset active) on the lanes in use for LANE_LO cycles, then released for LANE_HI cycles. `link_stat_clr` then pulses for exactly one cycle, still inside the disabled window.
- R6: The lanes in use are lane BASE_LANE alone in single-lane mode, and lanes BASE_LANE to BASE_LANE+3 in four-lane mode. All other lanes stay released (1) at all times.
- R7: After `port_disable` drops, the block waits SETTLE cycles and rechecks using the rule of R2/R3. A failed third recheck ends in fail.
- R8: `tries` reads 0 after a start and steps by one as each recovery attempt begins, up to 3.
- R9: After success the block waits up to OES_WAIT cycles for `out_err_stop` low. Then `err_stat_clr`, `phy_err_clr` and `log_err_clr` pulse together for one cycle and `seq_done` follows. If the wait expires first, the block ends in fail.
- R10: `seq_done` and `seq_fail` are sticky and never both high. The next start clears them. A start while a sequence is running is ignored.
- R11: Each wait is ceil(time × CLK_KHZ / 10^6) cycles for a time in ns, and at least one cycle.
- R12: A synchronous reset returns the block to idle. `port_disable`, `tx_discard`, all strobes, `seq_done` and `seq_fail` are low, `tries` is 0 and every lane is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launches a sequence when idle, done or failed |
| xcvr_rst_done | input | 1 | Transceiver reset has completed |
| port_ok | input | 1 | Port reports successful initialization |
| init_width | input | 3 | Width code the port initialized at |
| wide_mode | input | 1 | 1 = four-lane configuration, 0 = single lane; captured at start |
| out_err_stop | input | 1 | Output-error-stopped condition |
| port_disable | output | 1 | Holds the port disabled |
| tx_discard | output | 1 | Discards pending outbound packets |
| lane_rx_rst_n | output | LANES | Per-lane receive reset, 0 = reset active |
| link_stat_clr | output | 1 | One-cycle clear-all strobe for link status |
| err_stat_clr | output | 1 | One-cycle clear strobe for port error status |
| phy_err_clr | output | 1 | One-cycle clear strobe for physical-layer error detect |
| log_err_clr | output | 1 | One-cycle clear strobe for logical-layer error detect |
| seq_done | output | 1 | Sticky success flag |
| seq_fail | output | 1 | Sticky failure flag |
| tries | output | 2 | Recovery attempts used |

## Verification
Every output is decoded from the registered state. A result that an input decides at a clock edge therefore shows on the ports right after that edge. The fail flag for a start without transceiver reset appears one cycle after the start edge. Each timed phase lasts exactly its computed cycle count, and a recheck acts on the inputs seen in the single cycle after the settle wait. The bench model advances with the same clock edges. It reads inputs at the edge, updates its expectations straight after it, and compares them with the ports on the falling edge, so every cycle of each phase boundary is checked.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_POLL, ST_QUIESCE, ST_LANE_LO, ST_LANE_HI, ST_LSTAT_CLR,
    ST_UNDISC, ST_SETTLE, ST_RECHECK, ST_OES_WAIT, ST_ERR_CLR, ST_DONE, ST_FAIL
  } seq_st_e;

  localparam logic [2:0] FULL_WIDTH_CODE = 3'b010;
  localparam int unsigned MAX_TRIES = 3;

  // cycles = ceil(ns * kHz / 1e6), never below one
  function automatic int unsigned ns_to_cyc(longint unsigned ns, longint unsigned khz);
    longint unsigned c;
    c = (ns * khz + 64'd999_999) / 64'd1_000_000;
    return (c == 0) ? 1 : int'(c);
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic width_good(logic wide, logic [2:0] code);
    return !wide || (code == FULL_WIDTH_CODE);
  endfunction

endpackage

// File: rtl/lrs_timer.sv
module lrs_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (load)    cnt <= load_val;
    else if (cnt != 0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == 0);
endmodule

// File: rtl/lrs_lane_ctl.sv
module lrs_lane_ctl #(
  parameter int LANES     = 8,
  parameter int BASE_LANE = 0
) (
  input  logic             wide,
  input  logic             hold,
  output logic [LANES-1:0] rx_rst_n
);
  localparam int WIDE_SPAN = 4;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic in_use;
    if (i == BASE_LANE) begin : g_base
      assign in_use = 1'b1;
    end else if (i > BASE_LANE && i < BASE_LANE + WIDE_SPAN) begin : g_wide
      assign in_use = wide;
    end else begin : g_idle
      assign in_use = 1'b0;
    end
    assign rx_rst_n[i] = !(hold && in_use);
  end
endmodule

// File: rtl/lnk_recover_seq.sv
module lnk_recover_seq #(
  parameter int CLK_KHZ    = 125000,
  parameter int POLL_US    = 2000,
  parameter int QUIESCE_US = 50,
  parameter int LANE_LO_NS = 100,
  parameter int LANE_HI_NS = 300,
  parameter int SETTLE_US  = 24000,
  parameter int OES_US     = 1000000,
  parameter int LANES      = 8,
  parameter int BASE_LANE  = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             xcvr_rst_done,
  input  logic             port_ok,
  input  logic [2:0]       init_width,
  input  logic             wide_mode,
  input  logic             out_err_stop,
  output logic             port_disable,
  output logic             tx_discard,
  output logic [LANES-1:0] lane_rx_rst_n,
  output logic             link_stat_clr,
  output logic             err_stat_clr,
  output logic             phy_err_clr,
  output logic             log_err_clr,
  output logic             seq_done,
  output logic             seq_fail,
  output logic [1:0]       tries
);
  import lrs_pkg::*;

  localparam int unsigned POLL_C  = ns_to_cyc(longint'(POLL_US) * 1000, CLK_KHZ);
  localparam int unsigned QUIET_C = ns_to_cyc(longint'(QUIESCE_US) * 1000, CLK_KHZ);
  localparam int unsigned LO_C    = ns_to_cyc(longint'(LANE_LO_NS), CLK_KHZ);
  localparam int unsigned HI_C    = ns_to_cyc(longint'(LANE_HI_NS), CLK_KHZ);
  localparam int unsigned SETL_C  = ns_to_cyc(longint'(SETTLE_US) * 1000, CLK_KHZ);
  localparam int unsigned OES_C   = ns_to_cyc(longint'(OES_US) * 1000, CLK_KHZ);
  localparam int unsigned MAX_C   =
    max2(max2(max2(POLL_C, QUIET_C), max2(LO_C, HI_C)), max2(SETL_C, OES_C));
  localparam int CW = $clog2(MAX_C + 1);

  seq_st_e st, nxt;
  logic    wide_q;
  logic    tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;
  logic    try_inc, try_clr;
  logic    launch, link_good, link_bad;
  logic    lane_hold;

  // named events for checking and readability
  assign launch    = start && (st == ST_IDLE || st == ST_DONE || st == ST_FAIL);
  assign link_good = port_ok && width_good(wide_q, init_width);
  assign link_bad  = port_ok && !width_good(wide_q, init_width);

  always_comb begin
    nxt      = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    try_inc  = 1'b0;
    try_clr  = 1'b0;
    unique case (st)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start) begin
          try_clr = 1'b1;
          if (!xcvr_rst_done) begin
            nxt = ST_FAIL;
          end else begin
            nxt = ST_POLL; tmr_load = 1'b1; tmr_val = CW'(POLL_C - 1);
          end
        end
      end
      ST_POLL: begin
        if (link_good) begin
          nxt = ST_OES_WAIT; tmr_load = 1'b1; tmr_val = CW'(OES_C - 1);
        end else if (link_bad || tmr_zero) begin
          nxt = ST_QUIESCE; tmr_load = 1'b1; tmr_val = CW'(QUIET_C - 1); try_inc = 1'b1;
        end
      end
      ST_QUIESCE: if (tmr_zero) begin
        nxt = ST_LANE_LO; tmr_load = 1'b1; tmr_val = CW'(LO_C - 1);
      end
      ST_LANE_LO: if (tmr_zero) begin
        nxt = ST_LANE_HI; tmr_load = 1'b1; tmr_val = CW'(HI_C - 1);
      end
      ST_LANE_HI: if (tmr_zero) nxt = ST_LSTAT_CLR;
      ST_LSTAT_CLR: nxt = ST_UNDISC;
      ST_UNDISC: begin
        nxt = ST_SETTLE; tmr_load = 1'b1; tmr_val = CW'(SETL_C - 1);
      end
      ST_SETTLE: if (tmr_zero) nxt = ST_RECHECK;
      ST_RECHECK: begin
        if (link_good) begin
          nxt = ST_OES_WAIT; tmr_load = 1'b1; tmr_val = CW'(OES_C - 1);
        end else if (tries == 2'(MAX_TRIES)) begin
          nxt = ST_FAIL;
        end else begin
          nxt = ST_QUIESCE; tmr_load = 1'b1; tmr_val = CW'(QUIET_C - 1); try_inc = 1'b1;
        end
      end
      ST_OES_WAIT: begin
        if (!out_err_stop) nxt = ST_ERR_CLR;
        else if (tmr_zero) nxt = ST_FAIL;
      end
      ST_ERR_CLR: nxt = ST_DONE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      tries  <= '0;
      wide_q <= 1'b0;
    end else begin
      st <= nxt;
      if (launch)       wide_q <= wide_mode;
      if (try_clr)      tries  <= '0;
      else if (try_inc) tries  <= tries + 1'b1;
    end
  end

  lrs_timer #(.W(CW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  assign lane_hold = (st == ST_LANE_LO);

  lrs_lane_ctl #(.LANES(LANES), .BASE_LANE(BASE_LANE)) u_lanes (
    .wide(wide_q), .hold(lane_hold), .rx_rst_n(lane_rx_rst_n)
  );

  assign tx_discard    = (st == ST_QUIESCE) || (st == ST_LANE_LO) ||
                         (st == ST_LANE_HI) || (st == ST_LSTAT_CLR);
  assign port_disable  = tx_discard || (st == ST_UNDISC);
  assign link_stat_clr = (st == ST_LSTAT_CLR);
  assign err_stat_clr  = (st == ST_ERR_CLR);
  assign phy_err_clr   = (st == ST_ERR_CLR);
  assign log_err_clr   = (st == ST_ERR_CLR);
  assign seq_done      = (st == ST_DONE);
  assign seq_fail      = (st == ST_FAIL);
endmodule

// File: rtl/lrs_sva.sv
module lrs_sva #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             port_disable,
  input logic             tx_discard,
  input logic [LANES-1:0] lane_rx_rst_n,
  input logic             link_stat_clr,
  input logic             err_stat_clr,
  input logic             seq_done,
  input logic             seq_fail,
  input logic [1:0]       tries
);
  AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(seq_done && seq_fail)); // R10

  AST_TRIES_STEP: assert property (@(posedge clk) disable iff (rst)
    (tries != $past(tries)) |-> (tries == $past(tries) + 2'd1 || tries == 2'd0)); // R8

  AST_DISCARD_IN_DISABLE: assert property (@(posedge clk) disable iff (rst)
    tx_discard |-> port_disable); // R4

  AST_LANE_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
    (lane_rx_rst_n != {LANES{1'b1}}) |-> (tx_discard && port_disable)); // R5

  AST_LSTAT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    link_stat_clr |=> !link_stat_clr); // R5

  AST_DONE_AFTER_CLR: assert property (@(posedge clk) disable iff (rst)
    $rose(seq_done) |-> $past(err_stat_clr)); // R9

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!port_disable && !tx_discard && !seq_done && !seq_fail &&
             tries == 2'd0 && lane_rx_rst_n == {LANES{1'b1}})); // R12
endmodule

bind lnk_recover_seq lrs_sva #(.LANES(LANES)) u_sva (
  .clk(clk), .rst(rst), .port_disable(port_disable), .tx_discard(tx_discard),
  .lane_rx_rst_n(lane_rx_rst_n), .link_stat_clr(link_stat_clr),
  .err_stat_clr(err_stat_clr), .seq_done(seq_done), .seq_fail(seq_fail), .tries(tries)
);

// File: tb/sim_lnk_recover_seq.sv
`timescale 1ns/1ps
module sim_lnk_recover_seq;
  localparam int KHZ = 125000;
  localparam int LN = 8;
  localparam int BL = 2;

  // R11: bench-side cycle counts via real arithmetic
  function automatic int cyc(real ns);
    int c;
    c = int'($ceil(ns * real'(KHZ) / 1.0e6));
    return (c < 1) ? 1 : c;
  endfunction
  localparam int P_C = 250, Q_C = 125, LO_C = 13, HI_C = 38, S_C = 375, O_C = 500;

  logic clk = 0, rst = 1, start = 0, xcvr = 0, port_ok = 0, wide = 0, oes = 1;
  logic [2:0] iw = 3'b000;
  logic pd, disc, lsc, esc, pec, lec, done, fail;
  logic [LN-1:0] rxn;
  logic [1:0] tries;

  always #4 clk = ~clk;

  lnk_recover_seq #(.CLK_KHZ(KHZ), .POLL_US(2), .QUIESCE_US(1), .LANE_LO_NS(100),
    .LANE_HI_NS(300), .SETTLE_US(3), .OES_US(4), .LANES(LN), .BASE_LANE(BL)) u0 (
    .clk(clk), .rst(rst), .start(start), .xcvr_rst_done(xcvr), .port_ok(port_ok),
    .init_width(iw), .wide_mode(wide), .out_err_stop(oes), .port_disable(pd),
    .tx_discard(disc), .lane_rx_rst_n(rxn), .link_stat_clr(lsc), .err_stat_clr(esc),
    .phy_err_clr(pec), .log_err_clr(lec), .seq_done(done), .seq_fail(fail), .tries(tries));

  int checks = 0, fails = 0;
  bit cmp_en = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  bit e_pd, e_disc, e_lo, e_lsc, e_esc, e_done, e_fail, m_wide;
  int e_tries;

  function automatic bit good();
    return port_ok && (!m_wide || iw == 3'b010);
  endfunction

  function automatic logic [LN-1:0] exp_lanes();
    logic [LN-1:0] m;
    for (int i = 0; i < LN; i++) begin
      bit use_l;
      use_l = (i == BL) || (m_wide && i > BL && i < BL + 4);
      m[i] = !(e_lo && use_l);
    end
    return m;
  endfunction

  task automatic m_run();
    bit ok;
    e_done = 0; e_fail = 0; e_tries = 0; m_wide = wide;
    if (!xcvr) begin e_fail = 1; return; end
    ok = 0;
    for (int k = 0; k < P_C; k++) begin
      @(posedge clk);
      if (port_ok) begin ok = good(); break; end
    end
    if (!ok) begin
      for (int a = 1; a <= 3; a++) begin
        e_tries = a; e_pd = 1; e_disc = 1;
        repeat (Q_C) @(posedge clk); e_lo = 1;
        repeat (LO_C) @(posedge clk); e_lo = 0;
        repeat (HI_C) @(posedge clk); e_lsc = 1;
        @(posedge clk); e_lsc = 0; e_disc = 0;
        @(posedge clk); e_pd = 0;
        repeat (S_C) @(posedge clk);
        @(posedge clk); ok = good();
        if (ok) break;
      end
    end
    if (!ok) begin e_fail = 1; return; end
    ok = 0;
    for (int k = 0; k < O_C; k++) begin
      @(posedge clk);
      if (!oes) begin ok = 1; break; end
    end
    if (!ok) begin e_fail = 1; return; end
    e_esc = 1;
    @(posedge clk); e_esc = 0; e_done = 1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (!rst && start) m_run();
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) if (cmp_en) begin
    chk(pd == e_pd, "R4 port_disable", pd, e_pd);
    chk(disc == e_disc, "R4 tx_discard", disc, e_disc);
    chk(rxn == exp_lanes(), "R5/R6 lane_rx_rst_n", rxn, exp_lanes());
    chk(lsc == e_lsc, "R5 link_stat_clr", lsc, e_lsc);
    chk(esc == e_esc && pec == e_esc && lec == e_esc, "R9 error clears",
        {esc, pec, lec}, {3{e_esc}});
    chk(done == e_done, "R10 seq_done", done, e_done);
    chk(fail == e_fail, "R10 seq_fail", fail, e_fail);
    chk(int'(tries) == e_tries, "R8 tries", tries, e_tries);
  end

  // ---------------- stimulus ----------------
  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic wait_end();
    for (int k = 0; k < 4000 && !(e_done || e_fail); k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    // R11: bench rounding agrees with the chosen counts
    chk(cyc(100.0) == LO_C, "R11 lane low cycles", cyc(100.0), LO_C);
    chk(cyc(300.0) == HI_C, "R11 lane high cycles", cyc(300.0), HI_C);
    chk(cyc(0.001) == 1, "R11 minimum one cycle", cyc(0.001), 1);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!pd && !disc && rxn == '1 && !done && !fail && tries == 0,
        "R12 reset state", {pd, disc, done, fail}, 0);
    cmp_en = 1;

    // R1: no transceiver reset done
    xcvr = 0; pulse_start();
    chk(fail && !done && !pd, "R1 immediate fail", fail, 1);
    repeat (5) @(negedge clk);

    // R2: single lane, port_ok alone (code ignored)
    xcvr = 1; wide = 0; oes = 1; port_ok = 0; iw = 3'b111;
    pulse_start();
    repeat (20) @(negedge clk); port_ok = 1;
    repeat (30) @(negedge clk); oes = 0;
    wait_end();
    chk(done && tries == 0, "R2 single-lane success", {done, tries}, 4);

    // R9: out_err_stop stuck, ends in fail
    oes = 1; pulse_start(); wait_end();
    chk(fail && tries == 0, "R9 oes timeout fail", {fail, tries}, 4);

    // R3/R4/R5/R6/R10: downtrained wide link, recovery, mid-run start ignored
    wide = 1; port_ok = 1; iw = 3'b001; oes = 0;
    pulse_start();
    repeat (5) @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (200) @(negedge clk); iw = 3'b010;
    wait_end();
    chk(done && tries == 1, "R3 wide success after one try", {done, tries}, 5);

    // R7/R8: wide, never ok, three attempts then fail
    port_ok = 0; pulse_start(); wait_end();
    chk(fail && tries == 3, "R7 three tries then fail", {fail, tries}, 7);

    // R6/R10: restart from fail, single lane recovery on base lane only
    wide = 0; port_ok = 0; iw = 3'b000; oes = 0;
    pulse_start();
    repeat (400) @(negedge clk); port_ok = 1;
    wait_end();
    chk(done && tries == 1, "R6 single-lane recovery success", {done, tries}, 5);

    // R12: reset mid-sequence
    port_ok = 0; pulse_start();
    repeat (300) @(negedge clk);
    cmp_en = 0; rst = 1;
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk(!pd && !disc && rxn == '1 && !done && !fail && tries == 0,
        "R12 reset mid-run", {pd, disc, done, fail}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog expired actual=190000 expected<190000");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule